// File: doc/BRIEF.md
# I2C Master Event Flag and Interrupt Unit

This unit records the events that an I2C master's bus engine reports and turns them into one interrupt request. The engine gives a one-cycle strobe for each event: transaction complete, address or data acknowledge error, high-speed NACK error, and restart-transfer done. Each strobe sets a sticky flag in a status register. A mask register, with the same bit layout, selects which flags may raise the interrupt line.

Software reads both registers over a small register port. It clears a flag by writing a one to that flag's bit. A NACK is reported as an acknowledge error first and a completion some cycles later, so both flags accumulate until software clears them. A separate completion output tells waiting logic that either a transaction-complete or a restart-done flag is pending. A synchronous soft clear empties the status register and leaves the mask as it is.

Top module: `xfer_evt_irq`

## Requirements
- R1: After the asynchronous active-low reset, the status register, the mask register, `irq` and `cmpltPend` are all zero.
- R2: The status bits are placed as follows: transaction complete at bit 0, acknowledge error at bit 1, high-speed NACK at bit 2 and restart done at bit 4. An event strobe sets its bit at the next clock edge, and the bit stays set until it is cleared.
- R3: A write to the status register (`regAddr` = 0) clears every bit written as one and leaves every bit written as zero unchanged.
- R4: When an event strobe and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to the mask register (`regAddr` = 1) loads bits 0, 1, 2 and 4. `regRdData` returns the status register when `regAddr` = 0 and the mask register when `regAddr` = 1, with no wait cycle.
- R6: Bits 3 and 5 to 15 of both registers always read as zero, and writes to those bits have no effect.
- R7: `irq` is a register. In each cycle it equals the OR over all bits of (status AND mask) as they stood in the previous cycle.
- R8: An acknowledge-error strobe followed in a later cycle by a transaction-complete strobe leaves both bit 1 and bit 0 set.
- R9: `cmpltPend` is high exactly when status bit 0 or status bit 4 is set.
- R10: A `softClr` cycle clears every status bit at the next edge. It takes priority over event strobes in the same cycle and leaves the mask register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| softClr | input | 1 | Synchronous clear of all status flags |
| evtDone | input | 1 | Strobe: transaction complete |
| evtAckErr | input | 1 | Strobe: address or data acknowledge error |
| evtHsNack | input | 1 | Strobe: high-speed NACK error |
| evtRsDone | input | 1 | Strobe: restart transfer done |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 1 | Register select: 0 status, 1 mask |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the selected register |
| cmpltPend | output | 1 | A completion flag is pending |
| irq | output | 1 | Registered level interrupt request |

## Verification
Two things can land on the same status bit in one cycle: a new event strobe and a software write-one-to-clear. A soft clear can also meet event strobes. The random stimulus raises strobes, status writes and soft clears independently in each cycle, so such collisions happen often. Directed cycles also force the exact overlap on bit 0. After every edge, the bench compares the status read-back against a bench model in which a set beats a clear and a soft clear beats a set.

// File: rtl/xfer_evt_pkg.sv
package xfer_evt_pkg;
  localparam int REG_W       = 16;
  localparam int DONE_BIT    = 0;
  localparam int ACKERR_BIT  = 1;
  localparam int HSNACK_BIT  = 2;
  localparam int RSDONE_BIT  = 4;

  localparam logic [REG_W-1:0] IMPL_MASK =
      (REG_W'(1) << DONE_BIT)   | (REG_W'(1) << ACKERR_BIT) |
      (REG_W'(1) << HSNACK_BIT) | (REG_W'(1) << RSDONE_BIT);

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_MASK   = 1'b1;

  typedef struct packed {
    logic [REG_W-1:0] clrVec;
    logic             maskLoad;
    logic [REG_W-1:0] maskVal;
    logic             flush;
  } ctrlStrb_t;
endpackage

// File: rtl/xfer_evt_ctrl.sv
module xfer_evt_ctrl
  import xfer_evt_pkg::*;
(
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             softClr,
  output ctrlStrb_t        strb
);
  logic statusWr;
  logic maskWr;

  assign statusWr = regWrEn && (regAddr == ADDR_STATUS);
  assign maskWr   = regWrEn && (regAddr == ADDR_MASK);

  always_comb begin
    strb          = '0;
    strb.clrVec   = statusWr ? (regWrData & IMPL_MASK) : '0;
    strb.maskLoad = maskWr;
    strb.maskVal  = regWrData & IMPL_MASK;
    strb.flush    = softClr;
  end
endmodule

// File: rtl/xfer_evt_dp.sv
module xfer_evt_dp
  import xfer_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [REG_W-1:0] evtVec,
  output logic [REG_W-1:0] statusQ,
  output logic [REG_W-1:0] maskQ,
  output logic             irq
);
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             statusQ[b] <= 1'b0;
        else if (strb.flush)   statusQ[b] <= 1'b0;
        else if (evtVec[b])    statusQ[b] <= 1'b1;
        else if (strb.clrVec[b]) statusQ[b] <= 1'b0;
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              maskQ[b] <= 1'b0;
        else if (strb.maskLoad) maskQ[b] <= strb.maskVal[b];
      end
    end else begin : g_none
      assign statusQ[b] = 1'b0;
      assign maskQ[b]   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |(statusQ & maskQ);
  end
endmodule

// File: rtl/xfer_evt_irq.sv
module xfer_evt_irq
  import xfer_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             softClr,
  input  logic             evtDone,
  input  logic             evtAckErr,
  input  logic             evtHsNack,
  input  logic             evtRsDone,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             cmpltPend,
  output logic             irq
);
  ctrlStrb_t        strb;
  logic [REG_W-1:0] evtVec;
  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] maskQ;

  always_comb begin
    evtVec             = '0;
    evtVec[DONE_BIT]   = evtDone;
    evtVec[ACKERR_BIT] = evtAckErr;
    evtVec[HSNACK_BIT] = evtHsNack;
    evtVec[RSDONE_BIT] = evtRsDone;
  end

  xfer_evt_ctrl u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .softClr   (softClr),
    .strb      (strb)
  );

  xfer_evt_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .evtVec  (evtVec),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .irq     (irq)
  );

  assign regRdData = (regAddr == ADDR_MASK) ? maskQ : statusQ;
  assign cmpltPend = statusQ[DONE_BIT] | statusQ[RSDONE_BIT];
endmodule

// File: rtl/xfer_evt_irq_chk.sv
module xfer_evt_irq_chk
  import xfer_evt_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             softClr,
  input logic             evtDone,
  input logic             evtAckErr,
  input logic             evtHsNack,
  input logic             evtRsDone,
  input logic             regWrEn,
  input logic             regAddr,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] statusQ,
  input logic [REG_W-1:0] maskQ,
  input logic             irq
);
  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (evtDone && !softClr) |=> statusQ[DONE_BIT]); // R2

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!evtDone && !evtAckErr && !evtHsNack && !evtRsDone && !softClr &&
     !(regWrEn && regAddr == ADDR_STATUS)) |=> $stable(statusQ)); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_STATUS && regWrData[ACKERR_BIT] &&
     !evtAckErr) |=> !statusQ[ACKERR_BIT]); // R3

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_STATUS && regWrData[DONE_BIT] && evtDone &&
     !softClr) |=> statusQ[DONE_BIT]); // R4

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    irq == $past(|(statusQ & maskQ))); // R7

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (softClr && !(regWrEn && regAddr == ADDR_MASK)) |=>
      (statusQ == '0) && $stable(maskQ)); // R10
endmodule

bind xfer_evt_irq xfer_evt_irq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .softClr   (softClr),
  .evtDone   (evtDone),
  .evtAckErr (evtAckErr),
  .evtHsNack (evtHsNack),
  .evtRsDone (evtRsDone),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .statusQ   (statusQ),
  .maskQ     (maskQ),
  .irq       (irq)
);

// File: tb/xfer_evt_irq_tb.sv
module xfer_evt_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 32'h5eed_1c2e;
  localparam logic [15:0] IMPL = 16'h0017;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softClr = 1'b0;
  logic        evtDone = 1'b0, evtAckErr = 1'b0, evtHsNack = 1'b0, evtRsDone = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        cmpltPend;
  logic        irq;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  logic [15:0] expStat = '0;
  logic [15:0] expMask = '0;
  logic        expIrq  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_evt_irq u_dut (
    .clk(clk), .rstN(rstN), .softClr(softClr),
    .evtDone(evtDone), .evtAckErr(evtAckErr), .evtHsNack(evtHsNack), .evtRsDone(evtRsDone),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .cmpltPend(cmpltPend), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // status bit positions: done 0, ackerr 1, hsnack 2, rsdone 4 (R2)
  function automatic logic [15:0] evtBits(input logic d, a, h, r);
    return {11'b0, r, 1'b0, h, a, d};
  endfunction

  function automatic logic [15:0] nextStat(input logic [15:0] s, input logic [15:0] ev,
                                           input logic sc, input logic we, input logic ad,
                                           input logic [15:0] wd);
    logic [15:0] clr;
    if (sc) return '0;
    clr = (we && !ad) ? wd : '0;
    return ((s & ~clr) | ev) & IMPL;
  endfunction

  task automatic readBack(input string tag);
    regAddr = 1'b0;
    #1;
    chk({tag, " status R2 R3 R4 R6 R10"}, regRdData, expStat);
    chk({tag, " cmpltPend R9"}, {15'b0, cmpltPend}, {15'b0, expStat[0] | expStat[4]});
    regAddr = 1'b1;
    #1;
    chk({tag, " mask R5 R6"}, regRdData, expMask);
    chk({tag, " irq R7"}, {15'b0, irq}, {15'b0, expIrq});
  endtask

  task automatic step(input string tag, input logic d, a, h, r, sc, we, ad,
                      input logic [15:0] wd);
    evtDone = d; evtAckErr = a; evtHsNack = h; evtRsDone = r;
    softClr = sc; regWrEn = we; regAddr = ad; regWrData = wd;
    @(posedge clk);
    #1;
    expIrq  = |(expStat & expMask);
    expStat = nextStat(expStat, evtBits(d, a, h, r), sc, we, ad, wd);
    if (we && ad) expMask = wd & IMPL;
    evtDone = 0; evtAckErr = 0; evtHsNack = 0; evtRsDone = 0;
    softClr = 0; regWrEn = 0; regWrData = '0;
    readBack(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(SEED);
    repeat (3) @(posedge clk);
    #2;
    readBack("R1 reset");
    rstN = 1'b1;
    #1;

    // R5 R6: mask write of all ones keeps only implemented bits
    step("R5 mask all", 0,0,0,0, 0, 1,1, 16'hFFFF);
    step("R7 idle", 0,0,0,0, 0, 0,0, 16'h0);
    // R8: ack error, then completion later
    step("R8 ackerr", 0,1,0,0, 0, 0,0, 16'h0);
    step("R8 gap", 0,0,0,0, 0, 0,0, 16'h0);
    step("R8 done", 1,0,0,0, 0, 0,0, 16'h0);
    chk("R8 both flags", expStat & 16'h0003, 16'h0003);
    // R3: clear only bit 1, bit 0 stays
    step("R3 clear ackerr", 0,0,0,0, 0, 1,0, 16'h0002);
    // R4: collision on bit 0
    step("R4 collide", 1,0,0,0, 0, 1,0, 16'h0001);
    // R6: unimplemented bits of status ignore writes
    step("R6 status ones", 0,0,0,0, 0, 1,0, 16'hFFE8);
    // R9: restart done alone signals completion
    step("R9 clear", 0,0,0,0, 0, 1,0, 16'hFFFF);
    step("R9 rsdone", 0,0,0,0, 0, 0,0, 16'h0) ;
    step("R9 rsdone set", 0,0,0,1, 0, 0,0, 16'h0);
    // R7: masked flag gives no irq
    step("R7 mask off", 0,0,0,0, 0, 1,1, 16'h0004);
    step("R7 masked", 0,0,0,0, 0, 0,0, 16'h0);
    step("R7 hsnack", 0,0,1,0, 0, 0,0, 16'h0);
    step("R7 irq up", 0,0,0,0, 0, 0,0, 16'h0);
    // R10: soft clear beats events and keeps mask
    step("R10 flush", 1,1,1,1, 1, 0,0, 16'h0);
    step("R10 after", 0,0,0,0, 0, 0,0, 16'h0);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] wd;
      logic we, ad;
      wd = 16'($urandom);
      we = ($urandom % 3) == 0;
      ad = ($urandom % 4) == 0;
      step("rand", ($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 6) == 0,
           ($urandom % 5) == 0, ($urandom % 16) == 0, we, ad, wd);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule